// File: doc/BRIEF.md
# Two-Wire Digital Potentiometer Command Controller

This block is the control side of a dual six-bit digital potentiometer. It sits on an open-drain two-wire serial bus as a slave. It watches the clock and data lines for start and stop conditions and matches its slave address. It then decodes an instruction byte that acts on one of two wiper positions. Each wiper has a volatile wiper register and four data registers that stand in for nonvolatile storage.

Every instruction begins with a three-part header: a start condition, the address byte and the instruction byte. A read or write of a wiper register or a data register adds one data byte. A transfer between a data register and the wiper has no data byte, and a global variant acts on both pots at once. A write into a data register counts as nonvolatile. It takes effect at the stop condition and starts an internal write timer. While that timer runs the block refuses its address, so the host can poll until the write finishes. A write-protect input, active low, suppresses all such writes.

The block drives the bus only by pulling data low. The surrounding chip combines that pull enable with the pad.

Top module: `wiper_cmd_ctrl`

## Requirements
- R1: The address byte is acknowledged only when its upper nibble is 0101 and its lower nibble equals `dev_addr_i`. Any other address gets no ACK and the rest of the transfer is ignored.
- R2: The instruction byte is laid out as opcode in bits 7..4, select code R1,R0 in bits 3..2, bit 1 and pot select in bit 0. It is acknowledged only for a known opcode with bit 1 at zero. Otherwise it gets no ACK, no register changes, and the block waits for the next start.
- R3: Opcode 1010 followed by a data byte 00,D5..D0 loads D5..D0 into the wiper of the pot chosen by bit 0, and the data byte is acknowledged.
- R4: Opcode 1001 makes the block send the selected wiper as 00,D5..D0, most significant bit first, one bit per clock low period.
- R5: Opcode 1100 with a data byte writes a data register, and opcode 1011 reads one back in the same format as R4. The select code picks the register as 00 to 0, 10 to 1, 01 to 2 and 11 to 3.
- R6: Opcode 1101 copies the selected data register of the chosen pot into that pot's wiper at the end of the instruction ACK, with no write timer.
- R7: Opcode 0001 copies the selected data register of each pot into its own wiper, on both pots at once.
- R8: Opcode 1110 stores the chosen pot's wiper into its selected data register. Opcode 1000 does the same for both pots. The store happens at the stop condition.
- R9: While `wp_n_i` is low at the stop, a pending data-register write is dropped. No register changes and the write timer does not start.
- R10: After the stop of a data-register write, the address byte is refused for WRITE_CYCLES clock cycles. After that it is acknowledged again.
- R11: After reset both wipers read 0 and the bus is released. A stop condition in the middle of a byte abandons the transfer with no register change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| dev_addr_i | input | 4 | Strapped low nibble of the slave address |
| wp_n_i | input | 1 | Low blocks data-register writes |
| wiper0_o | output | WIPER_W | Wiper position of pot 0 |
| wiper1_o | output | WIPER_W | Wiper position of pot 1 |

## Verification
Two events can land on the same clock edge. One is the last count of the nonvolatile write timer. The other is the ACK decision for an address byte, which depends on whether the timer is still running. The bench provokes this collision by polling right after a data-register write with back-to-back address-only transfers until one is accepted. It then judges that the first poll was refused, and that the accepted one came no earlier than WRITE_CYCLES cycles after the stop and no later than one poll beyond that. It also reads the register back to confirm the written value.

// File: rtl/wcc_pkg.sv
package wcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } st_t;

    localparam logic [3:0] TYPE_ID     = 4'b0101;
    localparam logic [3:0] OP_RD_WCR   = 4'b1001;
    localparam logic [3:0] OP_WR_WCR   = 4'b1010;
    localparam logic [3:0] OP_RD_DR    = 4'b1011;
    localparam logic [3:0] OP_WR_DR    = 4'b1100;
    localparam logic [3:0] OP_DR2WCR   = 4'b1101;
    localparam logic [3:0] OP_WCR2DR   = 4'b1110;
    localparam logic [3:0] OP_G_DR2WCR = 4'b0001;
    localparam logic [3:0] OP_G_WCR2DR = 4'b1000;

    function automatic logic op_known(input logic [3:0] op);
        case (op)
            OP_RD_WCR, OP_WR_WCR, OP_RD_DR, OP_WR_DR,
            OP_DR2WCR, OP_WCR2DR, OP_G_DR2WCR, OP_G_WCR2DR: op_known = 1'b1;
            default: op_known = 1'b0;
        endcase
    endfunction

    // ins field: {opcode[3:0], r1, r0, pot}
    typedef struct packed {
        st_t        st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [6:0] ins;
        logic       pull;
        logic       pend;
        logic       pend_wcr;
        logic       pend_glb;
        logic       pend_pot;
        logic [1:0] pend_idx;
        logic [7:0] pend_val;
    } ctl_t;

endpackage

// File: rtl/wcc_line_sync.sv
module wcc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[DEPTH-2:0], scl_i};
        sda_d = {sda_q[DEPTH-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_q[STAGES-1];
    assign scl_prev = scl_q[STAGES];
    assign sda_now  = sda_q[STAGES-1];
    assign sda_prev = sda_q[STAGES];

    assign scl_o      = scl_now;
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev;
    assign scl_fall_o = ~scl_now & scl_prev;
    assign start_o    = scl_now & scl_prev & ~sda_now & sda_prev;
    assign stop_o     = scl_now & scl_prev & sda_now & ~sda_prev;

endmodule

// File: rtl/wcc_store.sv
module wcc_store #(
    parameter int WIPER_W      = 6,
    parameter int NPOT         = 2,
    parameter int NREG         = 4,
    parameter int WRITE_CYCLES = 500000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPOT-1:0]           wcr_ld_i,
    input  logic                      wcr_from_dr_i,
    input  logic [WIPER_W-1:0]        wcr_val_i,
    input  logic [$clog2(NREG)-1:0]   dr_idx_i,
    input  logic [NPOT-1:0]           nv_en_i,
    input  logic                      nv_from_wcr_i,
    input  logic [WIPER_W-1:0]        nv_val_i,
    input  logic [$clog2(NPOT)-1:0]   rd_pot_i,
    input  logic [$clog2(NREG)-1:0]   rd_idx_i,
    output logic [WIPER_W-1:0]        rd_wcr_o,
    output logic [WIPER_W-1:0]        rd_dr_o,
    output logic                      busy_o,
    output logic [NPOT*WIPER_W-1:0]   wcr_o
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [NPOT*NREG*WIPER_W-1:0] dr_all;

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        logic [WIPER_W-1:0] wcr_d, wcr_q;
        logic [WIPER_W-1:0] dr_d [NREG];
        logic [WIPER_W-1:0] dr_q [NREG];

        always_comb begin
            wcr_d = wcr_q;
            if (wcr_ld_i[p]) wcr_d = wcr_from_dr_i ? dr_q[dr_idx_i] : wcr_val_i;
            dr_d = dr_q;
            if (nv_en_i[p]) dr_d[dr_idx_i] = nv_from_wcr_i ? wcr_q : nv_val_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wcr_q <= '0;
                for (int r = 0; r < NREG; r++) dr_q[r] <= '0;
            end else begin
                wcr_q <= wcr_d;
                dr_q  <= dr_d;
            end
        end

        assign wcr_o[p*WIPER_W +: WIPER_W] = wcr_q;
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            assign dr_all[(p*NREG+r)*WIPER_W +: WIPER_W] = dr_q[r];
        end
    end

    assign rd_wcr_o = wcr_o[rd_pot_i*WIPER_W +: WIPER_W];
    assign rd_dr_o  = dr_all[(rd_pot_i*NREG + rd_idx_i)*WIPER_W +: WIPER_W];

    logic [CW-1:0] tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (|nv_en_i)          tmr_d = CW'(WRITE_CYCLES);
        else if (tmr_q != '0)  tmr_d = tmr_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = (tmr_q != '0);

    // R10: the controller never commits a write while the timer runs
    a_r10_commit_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (|nv_en_i) |-> !busy_o);

    // R10: the timer drains by one each cycle
    a_r10_timer_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(|nv_en_i)) |=> (tmr_q == $past(tmr_q) - 1'b1));

    // R6: wipers move only on a load request
    a_r6_wiper_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wcr_ld_i == '0) |=> $stable(wcr_o));

endmodule

// File: rtl/wiper_cmd_ctrl.sv
module wiper_cmd_ctrl #(
    parameter int WIPER_W      = 6,
    parameter int NREG         = 4,
    parameter int WRITE_CYCLES = 500000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [3:0]         dev_addr_i,
    input  logic               wp_n_i,
    output logic [WIPER_W-1:0] wiper0_o,
    output logic [WIPER_W-1:0] wiper1_o
);
    import wcc_pkg::*;

    localparam int NPOT = 2;

    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

    wcc_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
    );

    logic [NPOT-1:0]    wcr_ld, nv_en;
    logic               wcr_from_dr, nv_from_wcr, busy;
    logic [WIPER_W-1:0] wcr_val, nv_val, rd_wcr, rd_dr;
    logic [1:0]         dr_idx;
    logic [NPOT*WIPER_W-1:0] wcr_all;

    ctl_t q, d;

    logic [3:0] opc;
    logic [1:0] sel_idx;
    logic       pot;
    logic [7:0] tx;

    assign opc     = q.ins[6:3];
    assign sel_idx = {q.ins[1], q.ins[2]};   // code 00->0, 10->1, 01->2, 11->3
    assign pot     = q.ins[0];

    wcc_store #(.WIPER_W(WIPER_W), .NPOT(NPOT), .NREG(NREG),
                .WRITE_CYCLES(WRITE_CYCLES)) i_store (
        .clk(clk), .rst_n(rst_n),
        .wcr_ld_i(wcr_ld), .wcr_from_dr_i(wcr_from_dr), .wcr_val_i(wcr_val),
        .dr_idx_i(dr_idx), .nv_en_i(nv_en), .nv_from_wcr_i(nv_from_wcr),
        .nv_val_i(nv_val), .rd_pot_i(pot), .rd_idx_i(sel_idx),
        .rd_wcr_o(rd_wcr), .rd_dr_o(rd_dr), .busy_o(busy), .wcr_o(wcr_all)
    );

    always_comb begin
        d           = q;
        wcr_ld      = '0;
        wcr_from_dr = 1'b0;
        wcr_val     = q.sh[WIPER_W-1:0];
        nv_en       = '0;
        nv_from_wcr = q.pend_wcr;
        nv_val      = q.pend_val[WIPER_W-1:0];
        dr_idx      = sel_idx;
        tx          = 8'((opc == OP_RD_WCR) ? rd_wcr : rd_dr);

        if (start) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.sh   = '0;
            d.pull = 1'b0;
            d.pend = 1'b0;
        end else if (stop) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
            d.pend = 1'b0;
            if (q.pend && wp_n_i) begin
                nv_en  = q.pend_glb ? 2'b11 : (q.pend_pot ? 2'b10 : 2'b01);
                dr_idx = q.pend_idx;
            end
        end else begin
            case (q.st)
                ST_ADDR, ST_INSTR, ST_WDATA: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd9;
                        case (q.st)
                            ST_ADDR:  d.pull = (q.sh[7:4] == TYPE_ID) &&
                                               (q.sh[3:0] == dev_addr_i) && !busy;
                            ST_INSTR: begin
                                d.pull = op_known(q.sh[7:4]) && !q.sh[1];
                                d.ins  = {q.sh[7:2], q.sh[0]};
                            end
                            default:  d.pull = 1'b1;
                        endcase
                        if (!d.pull) d.st = ST_HOLD;
                    end
                    if (scl_fall && q.cnt == 4'd9) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        d.sh   = '0;
                        d.st   = ST_HOLD;
                        if (q.st == ST_ADDR) begin
                            d.st = ST_INSTR;
                        end else if (q.st == ST_INSTR) begin
                            case (opc)
                                OP_RD_WCR, OP_RD_DR: begin
                                    d.st   = ST_RDATA;
                                    d.sh   = tx;
                                    d.pull = ~tx[7];
                                end
                                OP_WR_WCR, OP_WR_DR: d.st = ST_WDATA;
                                OP_DR2WCR: begin
                                    wcr_ld      = pot ? 2'b10 : 2'b01;
                                    wcr_from_dr = 1'b1;
                                end
                                OP_G_DR2WCR: begin
                                    wcr_ld      = 2'b11;
                                    wcr_from_dr = 1'b1;
                                end
                                default: begin   // wiper to data register forms
                                    d.pend     = 1'b1;
                                    d.pend_wcr = 1'b1;
                                    d.pend_glb = (opc == OP_G_WCR2DR);
                                    d.pend_pot = pot;
                                    d.pend_idx = sel_idx;
                                end
                            endcase
                        end else if (opc == OP_WR_WCR) begin
                            wcr_ld = pot ? 2'b10 : 2'b01;
                        end else begin
                            d.pend     = 1'b1;
                            d.pend_wcr = 1'b0;
                            d.pend_glb = 1'b0;
                            d.pend_pot = pot;
                            d.pend_idx = sel_idx;
                            d.pend_val = q.sh;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && q.cnt < 4'd8) d.cnt = q.cnt + 1'b1;
                    if (scl_fall && q.cnt != 4'd0 && q.cnt < 4'd8) begin
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.pull = ~q.sh[6];
                    end
                    if (scl_fall && q.cnt == 4'd8) begin
                        d.pull = 1'b0;
                        d.st   = ST_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;
    assign wiper0_o   = wcr_all[WIPER_W-1:0];
    assign wiper1_o   = wcr_all[2*WIPER_W-1:WIPER_W];

    // R10: an address decided while busy leaves the line released
    a_r10_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR && scl_fall && q.cnt == 4'd8 && busy) |=> !sda_pull_o);

    // R11: a stop always releases the data line
    a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_pull_o);

    // R4: the pull only moves while the clock is low, never in a high phase
    a_r4_pull_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && !start && !stop) |=> $stable(sda_pull_o));

endmodule

// File: tb/test_wiper_cmd_ctrl.sv
`timescale 1ns/1ps
module test_wiper_cmd_ctrl;

    localparam int WC   = 300;
    localparam int Q    = 6;
    localparam logic [3:0] PINS = 4'b1010;
    localparam logic [7:0] ADR  = {4'b0101, PINS};

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, wp_n = 1'b1;
    logic sda_pull;
    logic [5:0] w0, w1;
    logic sda_line;
    int   n_chk = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign sda_line = sda_m & ~sda_pull;

    wiper_cmd_ctrl #(.WRITE_CYCLES(WC)) i_wiper_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .dev_addr_i(PINS), .wp_n_i(wp_n),
        .wiper0_o(w0), .wiper1_o(w1)
    );

    // kind: 0 three-byte write, 1 three-byte read, 2 two-byte transfer, 3 bad opcode
    // chk : 0 none, 1 read value, 2 wiper0, 3 wiper1
    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] ins;
        logic [7:0] dat;
        logic [1:0] chk;
        logic [5:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'hA0, 8'h15, 2'd2, 6'h15, 4'd3},  // R3 wiper0
        '{2'd0, 8'hA1, 8'h2A, 2'd3, 6'h2A, 4'd3},  // R3 wiper1
        '{2'd1, 8'h90, 8'h00, 2'd1, 6'h15, 4'd4},  // R4
        '{2'd1, 8'h91, 8'h00, 2'd1, 6'h2A, 4'd4},  // R4
        '{2'd0, 8'hC8, 8'h33, 2'd0, 6'h00, 4'd5},  // R5 code 10
        '{2'd0, 8'hC4, 8'h0C, 2'd0, 6'h00, 4'd5},  // R5 code 01
        '{2'd1, 8'hB8, 8'h00, 2'd1, 6'h33, 4'd5},  // R5
        '{2'd1, 8'hB4, 8'h00, 2'd1, 6'h0C, 4'd5},  // R5
        '{2'd2, 8'hD8, 8'h00, 2'd2, 6'h33, 4'd6},  // R6
        '{2'd2, 8'hED, 8'h00, 2'd0, 6'h00, 4'd8},  // R8 single
        '{2'd1, 8'hBD, 8'h00, 2'd1, 6'h2A, 4'd8},  // R8
        '{2'd2, 8'h14, 8'h00, 2'd3, 6'h00, 4'd7},  // R7 global
        '{2'd1, 8'h90, 8'h00, 2'd1, 6'h0C, 4'd7},  // R7
        '{2'd0, 8'hA1, 8'h3F, 2'd3, 6'h3F, 4'd3},  // R3
        '{2'd2, 8'h80, 8'h00, 2'd0, 6'h00, 4'd8},  // R8 global
        '{2'd1, 8'hB0, 8'h00, 2'd1, 6'h0C, 4'd8},  // R8
        '{2'd1, 8'hB1, 8'h00, 2'd1, 6'h3F, 4'd8},  // R8
        '{2'd3, 8'h20, 8'h00, 2'd2, 6'h0C, 4'd2},  // R2 unknown opcode
        '{2'd3, 8'hF2, 8'h00, 2'd2, 6'h0C, 4'd2}   // R2 bit 1 set
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic bit_tx(input logic b);
        sda_m = b; wq(); scl = 1'b1; wq(); scl = 1'b0; wq();
    endtask

    task automatic bit_rx(output logic b);
        sda_m = 1'b1; wq(); scl = 1'b1;
        repeat (Q/2) @(negedge clk);
        b = sda_line;
        repeat (Q - Q/2) @(negedge clk);
        scl = 1'b0; wq();
    endtask

    task automatic byte_tx(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_tx(v[i]);
        bit_rx(a);
        ack = ~a;
    endtask

    task automatic byte_rx(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_rx(b);
            v[i] = b;
        end
        bit_tx(1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rv;
        string rq;
        int t0, polls;

        repeat (5) @(negedge clk);
        // R11 reset state
        check("R11", {7'd0, sda_pull}, 8'h00);
        check("R11", {2'b0, w0}, 8'h00);
        check("R11", {2'b0, w1}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            rq = $sformatf("R%0d", VECS[k].req);
            bus_start();
            byte_tx(ADR, ack);
            check("R1", {7'd0, ack}, 8'h01);
            byte_tx(VECS[k].ins, ack);
            check(VECS[k].kind == 2'd3 ? "R2" : rq, {7'd0, ack},
                  VECS[k].kind == 2'd3 ? 8'h00 : 8'h01);
            if (VECS[k].kind == 2'd0) begin
                byte_tx(VECS[k].dat, ack);
                check(rq, {7'd0, ack}, 8'h01);
            end else if (VECS[k].kind == 2'd1) begin
                byte_rx(rv);
                check(rq, rv, {2'b00, VECS[k].exp});
            end
            bus_stop();
            repeat (WC + 40) @(negedge clk);
            if (VECS[k].chk == 2'd2) check(rq, {2'b0, w0}, {2'b00, VECS[k].exp});
            if (VECS[k].chk == 2'd3) check(rq, {2'b0, w1}, {2'b00, VECS[k].exp});
        end

        // R1 wrong device address and wrong type identifier
        bus_start(); byte_tx(8'h5B, ack); bus_stop();
        check("R1", {7'd0, ack}, 8'h00);
        bus_start(); byte_tx(8'h6A, ack); bus_stop();
        check("R1", {7'd0, ack}, 8'h00);

        // R9 write protect drops the data-register write and the timer
        wp_n = 1'b0;
        bus_start(); byte_tx(ADR, ack); byte_tx(8'hC0, ack); byte_tx(8'h11, ack); bus_stop();
        bus_start(); byte_tx(ADR, ack); bus_stop();
        check("R9", {7'd0, ack}, 8'h01);
        wp_n = 1'b1;
        bus_start(); byte_tx(ADR, ack); byte_tx(8'hB0, ack); byte_rx(rv); bus_stop();
        check("R9", rv, 8'h0C);

        // R10 acknowledge polling across the end of the write timer
        bus_start(); byte_tx(ADR, ack); byte_tx(8'hC0, ack); byte_tx(8'h22, ack); bus_stop();
        t0 = cyc;
        polls = 0;
        ack = 1'b0;
        while (!ack && polls < 20) begin
            bus_start(); byte_tx(ADR, ack); bus_stop();
            if (polls == 0) check("R10", {7'd0, ack}, 8'h00);
            polls++;
        end
        check("R10", {7'd0, ack}, 8'h01);
        check("R10", {7'd0, (cyc - t0) >= WC}, 8'h01);
        check("R10", {7'd0, (cyc - t0) <= WC + 400}, 8'h01);
        bus_start(); byte_tx(ADR, ack); byte_tx(8'hB0, ack); byte_rx(rv); bus_stop();
        check("R10", rv, 8'h22);

        // R11 stop in the middle of a data byte abandons the write
        bus_start(); byte_tx(ADR, ack); byte_tx(8'hA0, ack);
        bit_tx(1'b1); bit_tx(1'b0); bit_tx(1'b1); bit_tx(1'b1);
        bus_stop();
        repeat (20) @(negedge clk);
        check("R11", {2'b0, w0}, 8'h0C);
        check("R11", {7'd0, sda_pull}, 8'h00);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule